// File: doc/BRIEF.md
# Line Sensor Readout Controller

This block drives a chain of self-scanning photodiode line sensors from the host side. It derives the sensor clock from the system clock by a fixed division. It generates the sensor reset pulse, whose high time sets the charge integration time. It collects one ADC sample for every trigger pulse the sensors return. Every sensor edge it generates lands exactly on a sensor-clock rising edge. The reset pulse never rises while pixels are still being shifted out. Each line is at least as long as the sensors need for the programmed pixel count.

When sensors are cascaded, they share the clock and reset lines. Their trigger outputs are ORed, and so are their end-of-scan outputs. The controller therefore sees one trigger stream and one end-of-scan stream. Each trigger rising edge writes the ADC word to a line buffer through a write strobe with a pixel address. The address restarts at zero on every line. The end-of-scan edge, or a timeout if it never comes, closes the line. The controller then pulses `line_done` and reports whether the line held exactly the expected number of samples.

The controller is built around one state machine:
- `ST_IDLE` is the state after reset.
- `ST_INTEG` is the reset-high integration phase.
- `ST_READ` is the reset-low readout phase.

The transitions are:
- idle-to-integrate on the first sensor-clock rise.
- integrate-to-read when the integration count is reached.
- read-to-integrate when the line may close. This transition also starts the next line and emits `line_done`.

Top module: `lsr_readout`

## Requirements
- R1: `sen_clk` is a square wave. Each high level and each low level lasts exactly DIV_HALF system clock cycles.
- R2: `sen_rst` changes only in the system cycle in which `sen_clk` rises.
- R3: `sen_rst` stays high for H sensor clocks, where H is `cfg_integ` as captured when that line starts.
- R4: When `cfg_integ` is below HIGH_MIN (default 21), H is raised to HIGH_MIN.
- R5: During readout, each rising edge of `sen_trig` produces a single-cycle `pix_we` pulse. The pulse carries `pix_data` equal to `adc_data` at capture time. `pix_addr` starts at 0 on each line and goes up by one per capture.
- R6: Triggers beyond the captured pixel count N (`cfg_npix` at line start) produce no write. Addresses therefore stay within 0..N-1.
- R7: Trigger edges while `sen_rst` is high produce no write.
- R8: `line_done` is a one-cycle pulse. It is issued in the cycle `sen_rst` rises to end a readout. `cnt_err` is 0 when exactly N samples were captured and an end-of-scan edge was seen.
- R9: `cnt_err` is 1 after a line whose capture count differs from N. It holds until the next `line_done`.
- R10: After `sen_rst` falls, it does not rise again until a `sen_eos` rising edge has been observed (timeout aside).
- R11: Each line period is at least 4N+17 sensor clocks. Each low phase is at least LOW_MIN (default 20) sensor clocks.
- R12: If no end-of-scan edge arrives, the line closes 4N+TO_PAD sensor clocks after `sen_rst` fell, with `cnt_err` = 1. TO_PAD defaults to 40.
- R13: While `rst_n` is low, `sen_clk`, `sen_rst`, `pix_we`, `line_done` and `cnt_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_integ | input | INT_W | Integration time in sensor clocks, captured at line start |
| cfg_npix | input | PIX_W | Total pixels read serially per line, captured at line start |
| adc_data | input | DATA_W | Digitised video sample |
| sen_trig | input | 1 | ORed sensor trigger (asynchronous) |
| sen_eos | input | 1 | ORed sensor end-of-scan (asynchronous) |
| sen_clk | output | 1 | Sensor clock |
| sen_rst | output | 1 | Sensor reset / integration pulse |
| pix_we | output | 1 | Line buffer write strobe |
| pix_addr | output | PIX_W | Line buffer write address |
| pix_data | output | DATA_W | Line buffer write data |
| line_done | output | 1 | One-cycle end-of-line pulse |
| cnt_err | output | 1 | Capture count mismatch for the last closed line |

## Verification
The bench models a cascaded sensor. It returns a chosen number of triggers and an end-of-scan edge at a chosen clock, or none at all.

It targets the following corner cases:
- An integration value below the floor. A design that skipped the clamp would shorten the reset pulse.
- An early end-of-scan with a large pixel count. A controller that closed on end-of-scan alone would start the next line before the minimum period.
- A missing end-of-scan. Without the timeout the controller would hang in readout.
- Surplus triggers. These would write past the line buffer end if captures were not limited to N.
- A stray trigger during integration. A wrong design would write it to address 0.

Throughout the run, the bench also checks the sensor clock level widths and the alignment of reset edges to clock rises. A divider or sequencer off by one cycle shows up there.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;

    // Line sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INTEG = 2'd1,
        ST_READ  = 2'd2
    } line_st_e;

    // Fixed part of the minimum line period, rounded up to whole sensor clocks
    localparam int unsigned FRAME_FIXED = 17;
    // Sensor clocks consumed per pixel
    localparam int unsigned CLK_PER_PIX = 4;

endpackage

// File: rtl/lsr_clkdiv.sv
`timescale 1ns/1ps
module lsr_clkdiv #(
    parameter int unsigned DIV_HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic sen_clk,
    output logic rise_evt
);

    localparam int unsigned CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] div_cnt;
    logic          wrap;

    assign wrap     = (div_cnt == LAST);
    // Asserted in the cycle whose closing edge raises sen_clk
    assign rise_evt = wrap & ~sen_clk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            sen_clk <= 1'b0;
        end else if (wrap) begin
            div_cnt <= '0;
            sen_clk <= ~sen_clk;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Checker: run length of each sensor clock level
    logic [CW:0] chk_run;
    logic        chk_prev;
    logic        chk_armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_run   <= '0;
            chk_prev  <= 1'b0;
            chk_armed <= 1'b0;
        end else begin
            chk_prev <= sen_clk;
            if (sen_clk != chk_prev) begin
                chk_run   <= (CW+1)'(1);
                chk_armed <= 1'b1;
            end else begin
                chk_run <= chk_run + 1'b1;
            end
        end
    end

    a_r1_level_len: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sen_clk) && chk_armed) |-> (chk_run == (CW+1)'(DIV_HALF)));

endmodule

// File: rtl/lsr_edge_sync.sv
`timescale 1ns/1ps
module lsr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES-1:0] sr;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sr[STAGES-1];
    end

    assign rise = sr[STAGES-1] & ~prev;

    a_r5_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/lsr_line_fsm.sv
`timescale 1ns/1ps
module lsr_line_fsm
    import lsr_pkg::*;
#(
    parameter int unsigned INT_W    = 16,
    parameter int unsigned PIX_W    = 10,
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned HIGH_MIN = 21,
    parameter int unsigned LOW_MIN  = 20,
    parameter int unsigned TO_PAD   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_evt,
    input  logic              trig_rise,
    input  logic              eos_rise,
    input  logic [INT_W-1:0]  cfg_integ,
    input  logic [PIX_W-1:0]  cfg_npix,
    input  logic [DATA_W-1:0] adc_data,
    output logic              sen_rst,
    output logic              pix_we,
    output logic [PIX_W-1:0]  pix_addr,
    output logic [DATA_W-1:0] pix_data,
    output logic              line_done,
    output logic              cnt_err
);

    localparam int unsigned BASE_W = (INT_W > PIX_W + 2) ? INT_W : PIX_W + 2;
    localparam int unsigned CNT_W  = BASE_W + 2;
    localparam int unsigned CAP_W  = PIX_W + 1;
    localparam logic [INT_W-1:0] HMIN_V = INT_W'(HIGH_MIN);

    line_st_e st, nxt;

    logic [INT_W-1:0] hi_len_q;
    logic [PIX_W-1:0] npix_q;
    logic [CNT_W-1:0] ph_cnt;
    logic [CAP_W-1:0] cap_cnt;
    logic             eos_seen_q;

    logic [CNT_W-1:0] cnt_nx, per_min, tmo_lim, hi_ext, span;
    logic [INT_W-1:0] hi_clamp;
    logic             eos_any, close_ok, tmo_hit, hi_done;
    logic             enter_int, enter_read;

    always_comb begin
        cnt_nx   = ph_cnt + 1'b1;
        per_min  = (CNT_W'(npix_q) * CNT_W'(CLK_PER_PIX)) + CNT_W'(FRAME_FIXED);
        tmo_lim  = (CNT_W'(npix_q) * CNT_W'(CLK_PER_PIX)) + CNT_W'(TO_PAD);
        hi_ext   = CNT_W'(hi_len_q);
        span     = hi_ext + cnt_nx;
        eos_any  = eos_seen_q | eos_rise;
        close_ok = (cnt_nx >= CNT_W'(LOW_MIN)) && eos_any && (span >= per_min);
        tmo_hit  = (cnt_nx >= tmo_lim);
        hi_done  = (cnt_nx >= hi_ext);
        hi_clamp = (cfg_integ < HMIN_V) ? HMIN_V : cfg_integ;
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (rise_evt)                          nxt = ST_INTEG;
            ST_INTEG: if (rise_evt && hi_done)               nxt = ST_READ;
            ST_READ:  if (rise_evt && (close_ok || tmo_hit)) nxt = ST_INTEG;
            default:                                         nxt = ST_IDLE;
        endcase
    end

    assign enter_int  = (nxt == ST_INTEG) && (st != ST_INTEG);
    assign enter_read = (nxt == ST_READ)  && (st != ST_READ);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Outputs and line datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sen_rst    <= 1'b0;
            pix_we     <= 1'b0;
            pix_addr   <= '0;
            pix_data   <= '0;
            line_done  <= 1'b0;
            cnt_err    <= 1'b0;
            hi_len_q   <= HMIN_V;
            npix_q     <= '0;
            ph_cnt     <= '0;
            cap_cnt    <= '0;
            eos_seen_q <= 1'b0;
        end else begin
            pix_we    <= 1'b0;
            line_done <= 1'b0;
            if (enter_int) begin
                sen_rst    <= 1'b1;
                hi_len_q   <= hi_clamp;
                npix_q     <= cfg_npix;
                ph_cnt     <= '0;
                cap_cnt    <= '0;
                eos_seen_q <= 1'b0;
                if (st == ST_READ) begin
                    line_done <= 1'b1;
                    cnt_err   <= (cap_cnt != CAP_W'(npix_q)) || !eos_any;
                end
            end else if (enter_read) begin
                sen_rst <= 1'b0;
                ph_cnt  <= '0;
            end else begin
                if (rise_evt) ph_cnt <= cnt_nx;
                if (st == ST_READ) begin
                    if (eos_rise) eos_seen_q <= 1'b1;
                    if (trig_rise) begin
                        if (cap_cnt < CAP_W'(npix_q)) begin
                            pix_we   <= 1'b1;
                            pix_addr <= cap_cnt[PIX_W-1:0];
                            pix_data <= adc_data;
                        end
                        if (cap_cnt != '1) cap_cnt <= cap_cnt + 1'b1;
                    end
                end
            end
        end
    end

    // Checker: sensor clocks counted while the reset pulse is high
    logic [CNT_W-1:0] chk_hi;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           chk_hi <= '0;
        else if (!sen_rst)    chk_hi <= '0;
        else if (rise_evt)    chk_hi <= chk_hi + 1'b1;
    end

    a_r4_high_floor: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sen_rst) |-> (chk_hi >= CNT_W'(HIGH_MIN)));

    a_r6_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> (pix_addr < npix_q));

    a_r7_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> ($past(st) == ST_READ));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    a_r8_done_with_rise: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> $rose(sen_rst));

endmodule

// File: rtl/lsr_readout.sv
`timescale 1ns/1ps
module lsr_readout #(
    parameter int unsigned DIV_HALF    = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned INT_W       = 16,
    parameter int unsigned PIX_W       = 10,
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned HIGH_MIN    = 21,
    parameter int unsigned LOW_MIN     = 20,
    parameter int unsigned TO_PAD      = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  cfg_integ,
    input  logic [PIX_W-1:0]  cfg_npix,
    input  logic [DATA_W-1:0] adc_data,
    input  logic              sen_trig,
    input  logic              sen_eos,
    output logic              sen_clk,
    output logic              sen_rst,
    output logic              pix_we,
    output logic [PIX_W-1:0]  pix_addr,
    output logic [DATA_W-1:0] pix_data,
    output logic              line_done,
    output logic              cnt_err
);

    logic rise_evt;
    logic trig_rise;
    logic eos_rise;

    lsr_clkdiv #(
        .DIV_HALF (DIV_HALF)
    ) u_clkdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .sen_clk  (sen_clk),
        .rise_evt (rise_evt)
    );

    lsr_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_trig_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sen_trig),
        .rise  (trig_rise)
    );

    lsr_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_eos_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sen_eos),
        .rise  (eos_rise)
    );

    lsr_line_fsm #(
        .INT_W    (INT_W),
        .PIX_W    (PIX_W),
        .DATA_W   (DATA_W),
        .HIGH_MIN (HIGH_MIN),
        .LOW_MIN  (LOW_MIN),
        .TO_PAD   (TO_PAD)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_evt  (rise_evt),
        .trig_rise (trig_rise),
        .eos_rise  (eos_rise),
        .cfg_integ (cfg_integ),
        .cfg_npix  (cfg_npix),
        .adc_data  (adc_data),
        .sen_rst   (sen_rst),
        .pix_we    (pix_we),
        .pix_addr  (pix_addr),
        .pix_data  (pix_data),
        .line_done (line_done),
        .cnt_err   (cnt_err)
    );

    a_r2_rst_on_clk_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sen_rst) |-> $rose(sen_clk));

endmodule

// File: tb/test_lsr_readout.sv
`timescale 1ns/1ps
module test_lsr_readout;

    localparam int DIVH   = 4;
    localparam int INT_W  = 16;
    localparam int PIX_W  = 10;
    localparam int DATA_W = 12;
    localparam int HMIN   = 21;
    localparam int LMIN   = 20;
    localparam int TOPAD  = 40;
    localparam int SCLK   = 2 * DIVH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [INT_W-1:0]  cfg_integ = 16'd30;
    logic [PIX_W-1:0]  cfg_npix  = 10'd8;
    logic [DATA_W-1:0] adc_data, adc_a, adc_b;
    logic              trig_a, trig_b, sen_eos, sen_trig;
    logic              sen_clk, sen_rst, pix_we, line_done, cnt_err;
    logic [PIX_W-1:0]  pix_addr;
    logic [DATA_W-1:0] pix_data;

    assign sen_trig = trig_a | trig_b;
    assign adc_data = trig_b ? adc_b : adc_a;

    lsr_readout #(
        .DIV_HALF (DIVH), .SYNC_STAGES (2), .INT_W (INT_W), .PIX_W (PIX_W),
        .DATA_W (DATA_W), .HIGH_MIN (HMIN), .LOW_MIN (LMIN), .TO_PAD (TOPAD)
    ) i_lsr_readout (
        .clk (clk), .rst_n (rst_n), .cfg_integ (cfg_integ), .cfg_npix (cfg_npix),
        .adc_data (adc_data), .sen_trig (sen_trig), .sen_eos (sen_eos),
        .sen_clk (sen_clk), .sen_rst (sen_rst), .pix_we (pix_we),
        .pix_addr (pix_addr), .pix_data (pix_data), .line_done (line_done),
        .cnt_err (cnt_err)
    );

    int n_run = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(input int i);
        return DATA_W'((i * 37 + 5) % 4096);
    endfunction

    // Sensor model mode
    int m_nt = 8;
    int m_eos = 52;
    bit m_itrig = 1'b0;

    initial begin
        trig_a = 1'b0; sen_eos = 1'b0; adc_a = '0;
        forever begin
            int nt, ea;
            @(negedge sen_rst);
            nt = m_nt; ea = m_eos;
            for (int k = 1; k <= 1000; k++) begin
                @(posedge sen_clk);
                #1;
                if (sen_rst) break;
                if (k >= 20 && (k - 20) % 4 == 0 && (k - 20) / 4 < nt) begin
                    trig_a = 1'b1; adc_a = pat((k - 20) / 4);
                end
                if (k >= 22 && (k - 22) % 4 == 0 && (k - 22) / 4 < nt) trig_a = 1'b0;
                if (ea > 0 && k == ea)     sen_eos = 1'b1;
                if (ea > 0 && k == ea + 2) sen_eos = 1'b0;
            end
            trig_a = 1'b0; sen_eos = 1'b0;
        end
    end

    // Stray trigger while the reset pulse is high
    initial begin
        trig_b = 1'b0; adc_b = 12'hABC;
        forever begin
            @(posedge sen_rst);
            if (m_itrig) begin
                repeat (3) @(posedge sen_clk);
                #1 trig_b = 1'b1;
                repeat (2) @(posedge sen_clk);
                #1 trig_b = 1'b0;
            end
        end
    end

    // Monitor, sampled on the falling system clock edge
    int wr_cnt = 0, abc_seen = 0, last_hi = 0, last_lo = 0, hi_run = 0, lo_run = 0;
    int clk_run = 0, clk_chg = 0, clk_bad = 0, align_bad = 0, done_long = 0;
    bit last_err = 1'b0;
    logic [DATA_W-1:0] mem [0:63];
    logic p_clk = 1'b0, p_rst = 1'b0, p_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sen_clk == p_clk) clk_run++;
            else begin
                if (clk_chg > 0 && clk_run != DIVH) clk_bad++;
                clk_chg++;
                clk_run = 1;
            end
            if (sen_rst != p_rst && !(sen_clk && !p_clk)) align_bad++;
            if (sen_rst && !p_rst)      begin last_lo = lo_run; hi_run = 1; end
            else if (!sen_rst && p_rst) begin last_hi = hi_run; lo_run = 1; end
            else if (sen_rst)           hi_run++;
            else                        lo_run++;
            if (pix_we) begin
                wr_cnt++;
                if (pix_data == 12'hABC) abc_seen++;
                if (pix_addr < 64) mem[pix_addr] = pix_data;
            end
            if (line_done && p_done) done_long++;
            if (line_done) last_err = cnt_err;
            p_clk = sen_clk; p_rst = sen_rst; p_done = line_done;
        end
    end

    task automatic wait_done();
        do @(negedge clk); while (!line_done);
    endtask

    task automatic measure_line(input int integ, input int npix, input int nt,
                                input int eos_at, input bit itrig);
        cfg_integ = INT_W'(integ); cfg_npix = PIX_W'(npix);
        m_nt = nt; m_eos = eos_at; m_itrig = itrig;
        wait_done();
        #2;
        wr_cnt = 0; abc_seen = 0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        wait_done();
        #2;
        m_itrig = 1'b0;
    endtask

    function automatic int exp_lo(input int integ, input int npix, input int eos_at);
        int h, lo, tmo;
        h = (integ < HMIN) ? HMIN : integ;
        tmo = 4 * npix + TOPAD;
        if (eos_at == 0) return tmo;
        lo = LMIN;
        if (eos_at + 1 > lo) lo = eos_at + 1;
        if (4 * npix + 17 - h > lo) lo = 4 * npix + 17 - h;
        if (lo > tmo) lo = tmo;
        return lo;
    endfunction

    function automatic int mem_bad(input int n);
        int b = 0;
        for (int i = 0; i < n; i++) if (mem[i] !== pat(i)) b++;
        return b;
    endfunction

    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk(sen_clk == 1'b0, "R13 sen_clk in reset", int'(sen_clk), 0);
        chk(sen_rst == 1'b0, "R13 sen_rst in reset", int'(sen_rst), 0);
        chk(pix_we == 1'b0, "R13 pix_we in reset", int'(pix_we), 0);
        chk(line_done == 1'b0, "R13 line_done in reset", int'(line_done), 0);
        chk(cnt_err == 1'b0, "R13 cnt_err in reset", int'(cnt_err), 0);
    endtask

    task automatic t_normal(input int integ, input int npix);
        measure_line(integ, npix, npix, 20 + 4 * npix, 1'b0);
        chk(last_hi == integ * SCLK, "R3 reset high length", last_hi, integ * SCLK);
        chk(last_lo == exp_lo(integ, npix, 20 + 4 * npix) * SCLK, "R10 low waits for EOS",
            last_lo, exp_lo(integ, npix, 20 + 4 * npix) * SCLK);
        chk(wr_cnt == npix, "R5 write count", wr_cnt, npix);
        chk(mem_bad(npix) == 0, "R5 address/data order", mem_bad(npix), 0);
        chk(last_err == 1'b0, "R8 no mismatch", int'(last_err), 0);
    endtask

    task automatic t_clamp_minper();
        measure_line(5, 20, 0, 2, 1'b0);
        chk(last_hi == HMIN * SCLK, "R4 integration clamp", last_hi, HMIN * SCLK);
        chk(last_lo == exp_lo(5, 20, 2) * SCLK, "R11 minimum line period",
            last_lo, exp_lo(5, 20, 2) * SCLK);
        chk(wr_cnt == 0, "R9 no captures", wr_cnt, 0);
        chk(last_err == 1'b1, "R9 mismatch flagged", int'(last_err), 1);
    endtask

    task automatic t_short();
        measure_line(30, 8, 6, 44, 1'b0);
        chk(wr_cnt == 6, "R9 short line writes", wr_cnt, 6);
        chk(last_err == 1'b1, "R9 short line mismatch", int'(last_err), 1);
        chk(last_lo == exp_lo(30, 8, 44) * SCLK, "R11 short line low length",
            last_lo, exp_lo(30, 8, 44) * SCLK);
    endtask

    task automatic t_extra();
        measure_line(30, 8, 10, 60, 1'b0);
        chk(wr_cnt == 8, "R6 surplus triggers not written", wr_cnt, 8);
        chk(mem_bad(8) == 0, "R6 first N samples intact", mem_bad(8), 0);
        chk(last_err == 1'b1, "R9 surplus mismatch", int'(last_err), 1);
    endtask

    task automatic t_integ_trig();
        measure_line(30, 8, 8, 52, 1'b1);
        chk(abc_seen == 0, "R7 trigger in integration ignored", abc_seen, 0);
        chk(wr_cnt == 8, "R7 write count", wr_cnt, 8);
        chk(mem_bad(8) == 0, "R7 address 0 not disturbed", mem_bad(8), 0);
        chk(last_err == 1'b0, "R8 clean line", int'(last_err), 0);
    endtask

    task automatic t_timeout();
        measure_line(30, 4, 4, 0, 1'b0);
        chk(last_lo == (4 * 4 + TOPAD) * SCLK, "R12 timeout close", last_lo, (4 * 4 + TOPAD) * SCLK);
        chk(last_err == 1'b1, "R12 timeout flagged", int'(last_err), 1);
        chk(wr_cnt == 4, "R12 writes before timeout", wr_cnt, 4);
    endtask

    task automatic t_edges();
        chk(clk_chg > 100, "R1 sensor clock toggling", clk_chg, 101);
        chk(clk_bad == 0, "R1 level widths", clk_bad, 0);
        chk(align_bad == 0, "R2 reset edges on clock rise", align_bad, 0);
        chk(done_long == 0, "R8 line_done single cycle", done_long, 0);
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_normal(30, 8);
        t_normal(25, 3);
        t_clamp_minper();
        t_short();
        t_extra();
        t_integ_trig();
        t_timeout();
        t_edges();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule